// File: doc/BRIEF.md
# Burst-of-two double-rate synchronous SRAM core

This block is a synchronous static memory with a separate write-data bus and read-data bus. Each access moves two words and occupies one full period of the command clock. An access starts when the active-low load strobe is low at a rising-edge slot. In that slot the direction input chooses read (high) or write (low), and the address is captured. Write data and the per-lane active-low write selects are taken in both halves of the period: the first beat in the rising half and the second beat in the falling half.

The storage is split into two halves. The first beat of every burst lives in half 0 and the second in half 1, so one address names a whole burst. Read data comes back as two beats. The first beat appears on the falling-half slot one and a half periods after the command, and the second beat on the rising-half slot after that. A separate output-enable marks the beats, and the data bus reads as zero while it is low.

The model runs on a single clock at twice the command rate, `clk2x`. An internal phase flag names each edge as either the rising or the falling half of the command clock. That flag is brought out as `phase_o`, so a driver can line up its commands with the rising-half slots.

Top module: `bdr_sram`

## Requirements
- R1: After reset `q_oe` is 0, `q` is 0, and `phase_o` is 1, which marks the next `clk2x` edge as a rising-half slot. `phase_o` then alternates on every edge and is 1 before every rising-half slot.
- R2: A read command, taken at rising-half edge n, drives the half-0 word of its address on `q` from edge n+3 and the half-1 word from edge n+4, with `q_oe` at 1 for both beats.
- R3: When `ld_n` is 1 at a rising-half edge, no access starts. `rw`, `addr`, `d` and `bw_n` are ignored: no read beats follow and no stored word changes.
- R4: A write command at rising-half edge n stores the `d` value of edge n in half 0 and the `d` value of edge n+1 in half 1, both at the address of edge n.
- R5: Lane i covers bits 9i+8 down to 9i. For example, lane 0 covers bits 8:0 and lane 3 covers bits 35:27. `bw_n[i]` = 0 writes lane i and `bw_n[i]` = 1 keeps its old contents. Each beat is masked by the `bw_n` value of its own edge.
- R6: `ld_n` low at a falling-half edge starts no access, whatever the value of `rw`.
- R7: A read issued in the period right after a write to the same address returns the newly written lanes. A write issued in the period right after a read to the same address does not change the data that read returns.
- R8: Reads in consecutive periods produce an unbroken run of beats, with `q_oe` held at 1 throughout.
- R9: Whenever `q_oe` is 0, `q` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk2x | input | 1 | Clock at twice the command rate; each edge is one half-period slot |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_n | input | 1 | Active-low access strobe, taken at rising-half slots only |
| rw | input | 1 | Direction: 1 read, 0 write |
| addr | input | ADDR_W | Burst address, taken at rising-half slots |
| d | input | DATA_W | Write data, one beat per slot |
| bw_n | input | DATA_W/LANE_W | Active-low lane write selects, one per 9-bit lane |
| q | output | DATA_W | Read data beats |
| q_oe | output | 1 | High while `q` carries a read beat |
| phase_o | output | 1 | 1 when the next edge is a rising-half slot |

## Verification
The bench uses the default parameters: a 36-bit word made of four 9-bit lanes and 16 addresses per half. With 16 addresses, every location can be seeded before the masked writes are applied. With four lanes, each lane boundary can be hit by its own select pattern, and each beat can carry a different pattern. The short read latency lets three back-to-back reads and a write that follows a read share the pipeline inside a few periods. That brings both orderings of the write/read hazard within reach.

// File: rtl/bdr_pkg.sv
`timescale 1ns/1ps
package bdr_pkg;
  // Which half of the command clock the next clk2x edge stands for.
  typedef enum logic {PH_FALL = 1'b0, PH_RISE = 1'b1} phase_e;

  // Words per access.
  localparam int unsigned BURST_LEN = 2;
  // clk2x edges from a read command to its first returned beat.
  localparam int unsigned RD_LAT_EDGES = 3;
endpackage

// File: rtl/bdr_cmd_capture.sv
`timescale 1ns/1ps
module bdr_cmd_capture
  import bdr_pkg::*;
#(
  parameter int unsigned DATA_W = 36,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned LANES  = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  phase_e                              ph,
  input  logic                                ld_n,
  input  logic                                rw,
  input  logic [ADDR_W-1:0]                   addr,
  input  logic [DATA_W-1:0]                   d,
  input  logic [LANES-1:0]                    bw_n,
  output logic                                rd_issue,
  output logic                                wr_issue,
  output logic                                wr_commit,
  output logic [ADDR_W-1:0]                   wr_addr,
  output logic [BURST_LEN-1:0][DATA_W-1:0]    wr_data,
  output logic [BURST_LEN-1:0][LANES-1:0]     wr_sel_n
);
  logic at_rise;
  logic beat1_due;
  logic full_q;

  assign at_rise  = (ph == PH_RISE);
  assign rd_issue = at_rise && !ld_n && rw;
  assign wr_issue = at_rise && !ld_n && !rw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_addr   <= '0;
      wr_data   <= '0;
      wr_sel_n  <= '1;
      beat1_due <= 1'b0;
      full_q    <= 1'b0;
    end else begin
      beat1_due <= wr_issue;
      if (wr_issue) begin
        wr_addr     <= addr;
        wr_data[0]  <= d;
        wr_sel_n[0] <= bw_n;
      end
      if (beat1_due && !at_rise) begin
        wr_data[1]  <= d;
        wr_sel_n[1] <= bw_n;
        full_q      <= 1'b1;
      end else if (at_rise) begin
        full_q      <= 1'b0;
      end
    end
  end

  // A complete burst is written on the rising-half slot after its second beat.
  assign wr_commit = full_q;
endmodule

// File: rtl/bdr_array.sv
`timescale 1ns/1ps
module bdr_array
  import bdr_pkg::*;
#(
  parameter int unsigned DATA_W = 36,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned LANE_W = 9
) (
  input  logic                                       clk,
  input  logic                                       we,
  input  logic [ADDR_W-1:0]                          wr_addr,
  input  logic [BURST_LEN-1:0][DATA_W-1:0]           wr_data,
  input  logic [BURST_LEN-1:0][DATA_W/LANE_W-1:0]    wr_sel_n,
  input  logic [ADDR_W-1:0]                          rd_addr,
  input  logic [$clog2(BURST_LEN)-1:0]               rd_half,
  output logic [DATA_W-1:0]                          rd_word
);
  localparam int unsigned LANES = DATA_W / LANE_W;
  localparam int unsigned DEPTH = 2 ** ADDR_W;

  // Replace only the lanes whose active-low select is low.
  function automatic logic [DATA_W-1:0] lane_merge(
    input logic [DATA_W-1:0] old_w,
    input logic [DATA_W-1:0] new_w,
    input logic [LANES-1:0]  sel_n
  );
    logic [DATA_W-1:0] r;
    r = old_w;
    for (int i = 0; i < LANES; i++) begin
      if (!sel_n[i]) r[i*LANE_W +: LANE_W] = new_w[i*LANE_W +: LANE_W];
    end
    return r;
  endfunction

  logic [DATA_W-1:0] half_word [BURST_LEN];

  for (genvar h = 0; h < BURST_LEN; h++) begin : g_half
    logic [DATA_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we) mem[wr_addr] <= lane_merge(mem[wr_addr], wr_data[h], wr_sel_n[h]);
    end
    assign half_word[h] = mem[rd_addr];
  end

  assign rd_word = half_word[rd_half];
endmodule

// File: rtl/bdr_rd_return.sv
`timescale 1ns/1ps
module bdr_rd_return
  import bdr_pkg::*;
#(
  parameter int unsigned DATA_W = 36,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          rd_issue,
  input  logic [ADDR_W-1:0]             rd_addr_in,
  input  logic [DATA_W-1:0]             rd_word,
  output logic [ADDR_W-1:0]             look_addr,
  output logic [$clog2(BURST_LEN)-1:0]  look_half,
  output logic [DATA_W-1:0]             q,
  output logic                          q_oe
);
  localparam int unsigned STAGES = RD_LAT_EDGES + 1;
  localparam int unsigned TAP0   = RD_LAT_EDGES - 1;
  localparam int unsigned TAP1   = RD_LAT_EDGES;

  logic [STAGES-1:0] st_v;
  logic [ADDR_W-1:0] st_a [STAGES];
  logic fire0, fire1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_v <= '0;
      for (int i = 0; i < STAGES; i++) st_a[i] <= '0;
    end else begin
      st_v[0] <= rd_issue;
      st_a[0] <= rd_addr_in;
      for (int i = 1; i < STAGES; i++) begin
        st_v[i] <= st_v[i-1];
        st_a[i] <= st_a[i-1];
      end
    end
  end

  assign fire0     = st_v[TAP0];
  assign fire1     = st_v[TAP1];
  assign look_addr = fire0 ? st_a[TAP0] : st_a[TAP1];
  assign look_half = fire0 ? '0 : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q    <= '0;
      q_oe <= 1'b0;
    end else if (fire0 || fire1) begin
      q    <= rd_word;
      q_oe <= 1'b1;
    end else begin
      q    <= '0;
      q_oe <= 1'b0;
    end
  end
endmodule

// File: rtl/bdr_sram.sv
`timescale 1ns/1ps
module bdr_sram
  import bdr_pkg::*;
#(
  parameter int unsigned DATA_W = 36,
  parameter int unsigned LANE_W = 9,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                       clk2x,
  input  logic                       rst_n,
  input  logic                       ld_n,
  input  logic                       rw,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          d,
  input  logic [DATA_W/LANE_W-1:0]   bw_n,
  output logic [DATA_W-1:0]          q,
  output logic                       q_oe,
  output logic                       phase_o
);
  localparam int unsigned LANES  = DATA_W / LANE_W;
  localparam int unsigned BEAT_W = $clog2(BURST_LEN);

  phase_e ph_q;

  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_RISE;
    else        ph_q <= (ph_q == PH_RISE) ? PH_FALL : PH_RISE;
  end
  assign phase_o = (ph_q == PH_RISE);

  // Named events for the checker.
  logic rd_issue, wr_issue, wr_commit;
  logic [ADDR_W-1:0]                 wr_addr;
  logic [BURST_LEN-1:0][DATA_W-1:0]  wr_data;
  logic [BURST_LEN-1:0][LANES-1:0]   wr_sel_n;
  logic [ADDR_W-1:0]                 look_addr;
  logic [BEAT_W-1:0]                 look_half;
  logic [DATA_W-1:0]                 rd_word;

  bdr_cmd_capture #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LANES(LANES)) u_cap (
    .clk(clk2x), .rst_n(rst_n), .ph(ph_q), .ld_n(ld_n), .rw(rw), .addr(addr),
    .d(d), .bw_n(bw_n), .rd_issue(rd_issue), .wr_issue(wr_issue),
    .wr_commit(wr_commit), .wr_addr(wr_addr), .wr_data(wr_data), .wr_sel_n(wr_sel_n)
  );

  bdr_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_arr (
    .clk(clk2x), .we(wr_commit), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_sel_n(wr_sel_n), .rd_addr(look_addr), .rd_half(look_half), .rd_word(rd_word)
  );

  bdr_rd_return #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ret (
    .clk(clk2x), .rst_n(rst_n), .rd_issue(rd_issue), .rd_addr_in(addr),
    .rd_word(rd_word), .look_addr(look_addr), .look_half(look_half),
    .q(q), .q_oe(q_oe)
  );
endmodule

// File: rtl/bdr_sram_chk.sv
`timescale 1ns/1ps
module bdr_sram_chk #(
  parameter int unsigned DATA_W = 36
) (
  input logic              clk2x,
  input logic              rst_n,
  input logic              rise,
  input logic              rd_issue,
  input logic              wr_issue,
  input logic              wr_commit,
  input logic [DATA_W-1:0] q,
  input logic              q_oe
);
  // R2
  first_beat_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
    $past(rd_issue, 4) |-> q_oe);
  // R2
  second_beat_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
    $past(rd_issue, 5) |-> q_oe);
  // R3
  no_stray_beat_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
    q_oe |-> ($past(rd_issue, 4) || $past(rd_issue, 5)));
  // R4
  commit_after_write_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
    wr_commit |-> $past(wr_issue, 2));
  // R4
  commit_phase_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
    wr_commit |-> rise);
  // R9
  quiet_bus_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
    !q_oe |-> (q == '0));
endmodule

bind bdr_sram bdr_sram_chk #(.DATA_W(DATA_W)) u_chk (
  .clk2x(clk2x), .rst_n(rst_n), .rise(phase_o), .rd_issue(rd_issue),
  .wr_issue(wr_issue), .wr_commit(wr_commit), .q(q), .q_oe(q_oe)
);

// File: tb/bdr_sram_test.sv
`timescale 1ns/1ps
module bdr_sram_test;
  logic clk2x = 1'b0;
  logic rst_n = 1'b0;
  logic ld_n = 1'b1, rw = 1'b0;
  logic [3:0] addr = '0;
  logic [35:0] d = '0;
  logic [3:0] bw_n = '1;
  logic [35:0] q;
  logic q_oe, phase_o;

  always #4 clk2x = ~clk2x;

  bdr_sram uut (.clk2x(clk2x), .rst_n(rst_n), .ld_n(ld_n), .rw(rw), .addr(addr),
                .d(d), .bw_n(bw_n), .q(q), .q_oe(q_oe), .phase_o(phase_o));

  int n_chk = 0, n_fail = 0, ecnt = 0;
  bit done = 0;
  logic        exp_v [8];
  logic [35:0] exp_d [8];
  string       exp_tag [8];
  string       idle_tag = "R9";
  logic [35:0] mdl0 [16];
  logic [35:0] mdl1 [16];

  // Vector: {is_read, addr, beat0, beat1, sel0_n, sel1_n}
  localparam logic [84:0] VEC [8] = '{
    {1'b0, 4'd2,  36'h123456789, 36'hABCDEF012, 4'b0000, 4'b0000},
    {1'b1, 4'd2,  36'h0,         36'h0,         4'b1111, 4'b1111},
    {1'b0, 4'd2,  36'hFFFFFFFFF, 36'h000000000, 4'b1010, 4'b0101},
    {1'b1, 4'd2,  36'h0,         36'h0,         4'b1111, 4'b1111},
    {1'b0, 4'd9,  36'h0AAAAAAAA, 36'h555555555, 4'b1111, 4'b0111},
    {1'b1, 4'd9,  36'h0,         36'h0,         4'b1111, 4'b1111},
    {1'b0, 4'd15, 36'hC3C3C3C3C, 36'h3C3C3C3C3, 4'b0000, 4'b1111},
    {1'b1, 4'd15, 36'h0,         36'h0,         4'b1111, 4'b1111}
  };

  function automatic logic [35:0] mg(input logic [35:0] o, input logic [35:0] n,
                                     input logic [3:0] m);
    logic [35:0] r;
    for (int b = 0; b < 36; b++) r[b] = m[b / 9] ? o[b] : n[b];
    return r;
  endfunction

  task automatic chk(input string tag, input logic ok, input logic [39:0] act,
                     input logic [39:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sample_slot();
    int i;
    i = ecnt % 8;
    if (exp_v[i]) begin
      chk(exp_tag[i], q_oe === 1'b1 && q === exp_d[i], {3'b0, q_oe, q}, {3'b0, 1'b1, exp_d[i]});
      exp_v[i] = 1'b0;
    end else begin
      chk(idle_tag, q_oe === 1'b0 && q === 36'h0, {3'b0, q_oe, q}, 40'h0);
    end
  endtask

  task automatic half(input logic l, input logic r, input logic [3:0] a,
                      input logic [35:0] dv, input logic [3:0] mv);
    ld_n = l; rw = r; addr = a; d = dv; bw_n = mv;
    @(posedge clk2x);
    ecnt++;
    @(negedge clk2x);
    sample_slot();
  endtask

  task automatic cyc(input logic l, input logic r, input logic [3:0] a,
                     input logic [35:0] d0, input logic [35:0] d1,
                     input logic [3:0] m0, input logic [3:0] m1,
                     input logic lf, input logic rf, input string tag);
    chk("R1", phase_o === 1'b1, {39'h0, phase_o}, 40'h1);
    if (!l && r) begin
      exp_v[(ecnt + 4) % 8] = 1'b1; exp_d[(ecnt + 4) % 8] = mdl0[a]; exp_tag[(ecnt + 4) % 8] = tag;
      exp_v[(ecnt + 5) % 8] = 1'b1; exp_d[(ecnt + 5) % 8] = mdl1[a]; exp_tag[(ecnt + 5) % 8] = tag;
    end
    half(l, r, a, d0, m0);
    half(lf, rf, a, d1, m1);
    if (!l && !r) begin
      mdl0[a] = mg(mdl0[a], d0, m0);
      mdl1[a] = mg(mdl1[a], d1, m1);
    end
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    cyc(1'b0, 1'b1, a, 36'h0, 36'h0, 4'hF, 4'hF, 1'b1, 1'b0, tag);
  endtask

  task automatic wr(input logic [3:0] a, input logic [35:0] d0, input logic [35:0] d1,
                    input logic [3:0] m0, input logic [3:0] m1);
    cyc(1'b0, 1'b0, a, d0, d1, m0, m1, 1'b1, 1'b0, "R4");
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++)
      cyc(1'b1, 1'b0, 4'd0, 36'h0, 36'h0, 4'hF, 4'hF, 1'b1, 1'b0, "R9");
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin exp_v[i] = 1'b0; exp_d[i] = '0; exp_tag[i] = ""; end
    repeat (3) @(negedge clk2x);
    // R1: reset state
    chk("R1", q_oe === 1'b0, {39'h0, q_oe}, 40'h0);
    chk("R1", q === 36'h0, {4'h0, q}, 40'h0);
    chk("R1", phase_o === 1'b1, {39'h0, phase_o}, 40'h1);
    rst_n = 1'b1;

    // R4: seed every address with full-lane writes
    for (int a = 0; a < 16; a++) begin
      mdl0[a] = '0; mdl1[a] = '0;
      wr(4'(a), 36'(a) * 36'h111111111, ~(36'(a) * 36'h111111111), 4'h0, 4'h0);
    end
    idle(1);

    // R5: masked writes and reads from the table
    for (int i = 0; i < 8; i++) begin
      if (VEC[i][84])
        rd(VEC[i][83:80], (i <= 1) ? "R4" : "R5");
      else
        wr(VEC[i][83:80], VEC[i][79:44], VEC[i][43:8], VEC[i][7:4], VEC[i][3:0]);
      idle(3);
    end

    // R2: single read with exact beat timing
    rd(4'd0, "R2");
    idle(3);

    // R3: load high at a rising slot ignores a would-be write
    cyc(1'b1, 1'b0, 4'd5, 36'hDEADBEEF1, 36'hFEEDFACE2, 4'h0, 4'h0, 1'b1, 1'b0, "R3");
    idle_tag = "R3";
    idle(3);
    rd(4'd5, "R3");
    idle(3);

    // R6: load low only at falling slots
    idle_tag = "R6";
    cyc(1'b1, 1'b1, 4'd6, 36'h111100001, 36'h222200002, 4'h0, 4'h0, 1'b0, 1'b0, "R6");
    cyc(1'b1, 1'b1, 4'd6, 36'h0, 36'h0, 4'hF, 4'hF, 1'b0, 1'b1, "R6");
    idle(3);
    rd(4'd6, "R6");
    idle(3);
    idle_tag = "R9";

    // R7: write then read, read then write, same address
    wr(4'd3, 36'h9ABCDEF01, 36'h13579BDF0, 4'b0011, 4'b1100);
    rd(4'd3, "R7");
    idle(3);
    rd(4'd7, "R7");
    wr(4'd7, 36'h0F0F0F0F0, 36'hF0F0F0F0F, 4'h0, 4'h0);
    idle(1);
    rd(4'd7, "R7");
    idle(3);

    // R8: three reads back to back
    rd(4'd2, "R8");
    rd(4'd9, "R8");
    rd(4'd15, "R8");
    idle(4);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule